// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command register of an 8-bit parallel NOR flash model with a 19-bit byte address. It watches single-cycle bus writes (strobe, address, data) and recognises the multi-write unlock sequences that start a byte program, a whole-array erase or a single-sector erase. It also recognises the single-write commands for suspending and resuming a sector erase. Each recognised command leaves the block as a one-cycle pulse on its own output. The program pulse carries the target address and data, and the sector erase pulse carries the 3-bit sector number.

The embedded program/erase algorithm is outside the block. A level input reports that it is running, and a one-cycle input reports that it has finished. The block combines that input with its own suspend state into a two-bit mode: read array, busy or erase-suspended.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset every command pulse output is low and `mode` reads 0 (read array).
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h and then any data D at any address A give exactly one `pgm_go` pulse. The pulse is in the cycle after the fourth write, with `pgm_addr`=A and `pgm_data`=D.
- R3: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh and then 10h@555h give one `chip_go` pulse in the cycle after the last write.
- R4: The same five-write prefix followed by 30h at any address A gives one `sect_go` pulse in the cycle after the last write, with `sect_num`=A[18:16].
- R5: Any write whose address or data differs from the next expected step returns the decoder to its idle state and gives no pulse. A later correct sequence is then decoded from its first write.
- R6: F0h written at any step before the data write of a program returns the decoder to idle without a pulse.
- R7: Unlock steps compare only address bits [10:0] against 555h and 2AAh. Bits [18:11] may take any value.
- R8: While `alg_busy` is high, every write other than B0h is ignored. It gives no pulse and leaves the sequence state unchanged.
- R9: B0h at any address gives one `susp_go` pulse only if it is written while `alg_busy` is high, a sector erase has been issued, and that erase has not finished (no `alg_done`). After the pulse the block is suspended. B0h gives no pulse in any other case.
- R10: While the block is suspended, and the decoder is idle and `alg_busy` is low, 30h at any address gives one `resume_go` pulse and ends the suspension.
- R11: While the block is suspended, a program is issued only if its target sector differs from the suspended sector. Erase sequences give no pulse. An `alg_done` that arrives while suspended does not end the suspended erase.
- R12: `mode` is 1 (busy) while `alg_busy` is high. Otherwise it is 2 while suspended and 0 in all other cases.
- R13: At most one command pulse is high in any cycle, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data |
| alg_busy | input | 1 | Embedded algorithm running |
| alg_done | input | 1 | Embedded algorithm finished (one cycle) |
| pgm_go | output | 1 | Byte program command pulse |
| pgm_addr | output | 19 | Program target address |
| pgm_data | output | 8 | Program data |
| chip_go | output | 1 | Whole-array erase pulse |
| sect_go | output | 1 | Sector erase pulse |
| sect_num | output | 3 | Sector selected for erase |
| susp_go | output | 1 | Erase suspend pulse |
| resume_go | output | 1 | Erase resume pulse |
| mode | output | 2 | 0 read array, 1 busy, 2 erase-suspended |

## Verification
The assertions check on every cycle that:
- command pulses are exclusive and last one cycle;
- a write made while busy never produces a program, erase or resume pulse;
- a suspend pulse only follows a B0h write made while busy, and leaves the mode away from read;
- a resume pulse only follows a cycle spent suspended.

Only the bench scenarios can show the rest:
- that complete sequences produce their pulses with the right address, data and sector;
- that every broken or reset sequence is dropped;
- that the upper address bits are ignored during unlock;
- that suspension protects the erasing sector and survives a completing program.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CODE_KEY1  = 8'hAA;
  localparam logic [7:0] CODE_KEY2  = 8'h55;
  localparam logic [7:0] CODE_PROG  = 8'hA0;
  localparam logic [7:0] CODE_ERASE = 8'h80;
  localparam logic [7:0] CODE_CHIP  = 8'h10;
  localparam logic [7:0] CODE_SECT  = 8'h30;
  localparam logic [7:0] CODE_SUSP  = 8'hB0;

  localparam logic [10:0] KEY_ADDR_A = 11'h555;
  localparam logic [10:0] KEY_ADDR_B = 11'h2AA;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_K1, SQ_K2, SQ_PDATA, SQ_E1, SQ_E2, SQ_E3
  } seq_t;

  typedef enum logic [1:0] {
    MODE_READ = 2'd0,
    MODE_BUSY = 2'd1,
    MODE_SUSP = 2'd2
  } mode_t;

endpackage

// File: rtl/cmd_match.sv
module cmd_match
  import flash_cmd_pkg::*;
#(
  parameter int UNLOCK_W = 11
) (
  input  logic [UNLOCK_W-1:0] key_addr,
  input  logic [7:0]          data,
  output logic                at_a,
  output logic                at_b,
  output logic                d_key1,
  output logic                d_key2,
  output logic                d_prog,
  output logic                d_erase,
  output logic                d_chip,
  output logic                d_sect,
  output logic                d_susp
);

  localparam logic [UNLOCK_W-1:0] KA = KEY_ADDR_A[UNLOCK_W-1:0];
  localparam logic [UNLOCK_W-1:0] KB = KEY_ADDR_B[UNLOCK_W-1:0];

  always_comb begin
    at_a    = (key_addr == KA);
    at_b    = (key_addr == KB);
    d_key1  = (data == CODE_KEY1);
    d_key2  = (data == CODE_KEY2);
    d_prog  = (data == CODE_PROG);
    d_erase = (data == CODE_ERASE);
    d_chip  = (data == CODE_CHIP);
    d_sect  = (data == CODE_SECT);
    d_susp  = (data == CODE_SUSP);
  end

endmodule

// File: rtl/cmd_seq.sv
module cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              at_a,
  input  logic              at_b,
  input  logic              d_key1,
  input  logic              d_key2,
  input  logic              d_prog,
  input  logic              d_erase,
  input  logic              d_chip,
  input  logic              d_sect,
  input  logic              suspended,
  input  logic [SECT_W-1:0] susp_sect,
  output logic              pgm_go,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [7:0]        pgm_data,
  output logic              chip_go,
  output logic              sect_go,
  output logic [SECT_W-1:0] sect_num,
  output logic              resume_go
);

  seq_t st_q, st_n;
  logic pgm_n, chip_n, sect_n, res_n;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [SECT_W-1:0] wr_sect;

  assign wr_sect = wr_addr[ADDR_W-1 -: SECT_W];

  // Any mismatch, including the reset code, falls back to idle.
  always_comb begin
    st_n   = st_q;
    pgm_n  = 1'b0;
    chip_n = 1'b0;
    sect_n = 1'b0;
    res_n  = 1'b0;
    if (wr_ok) begin
      st_n = SQ_IDLE;
      case (st_q)
        SQ_IDLE: begin
          if (d_key1 && at_a)       st_n  = SQ_K1;
          else if (d_sect && suspended) res_n = 1'b1;
        end
        SQ_K1:    if (d_key2 && at_b) st_n = SQ_K2;
        SQ_K2: begin
          if (d_prog && at_a)                     st_n = SQ_PDATA;
          else if (d_erase && at_a && !suspended) st_n = SQ_E1;
        end
        SQ_PDATA: pgm_n = !suspended || (wr_sect != susp_sect);
        SQ_E1:    if (d_key1 && at_a) st_n = SQ_E2;
        SQ_E2:    if (d_key2 && at_b) st_n = SQ_E3;
        SQ_E3: begin
          chip_n = d_chip && at_a;
          sect_n = d_sect;
        end
        default: st_n = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      pgm_go    <= 1'b0;
      chip_go   <= 1'b0;
      sect_go   <= 1'b0;
      resume_go <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
    end else begin
      st_q      <= st_n;
      pgm_go    <= pgm_n;
      chip_go   <= chip_n;
      sect_go   <= sect_n;
      resume_go <= res_n;
      if (wr_ok) begin
        addr_q <= wr_addr;
        data_q <= wr_data;
      end
    end
  end

  assign pgm_addr = addr_q;
  assign pgm_data = data_q;
  assign sect_num = addr_q[ADDR_W-1 -: SECT_W];

endmodule

// File: rtl/susp_ctrl.sv
module susp_ctrl #(
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sect_go,
  input  logic [SECT_W-1:0] sect_id,
  input  logic              susp_req,
  input  logic              resume_go,
  input  logic              alg_done,
  output logic              suspended,
  output logic [SECT_W-1:0] susp_sect,
  output logic              susp_go
);

  logic              run_q, run_n;
  logic              sp_n, go_n;
  logic [SECT_W-1:0] sect_n;

  always_comb begin
    run_n  = run_q;
    sp_n   = suspended;
    sect_n = susp_sect;
    go_n   = 1'b0;
    if (sect_go) begin
      run_n  = 1'b1;
      sect_n = sect_id;
    end else if (susp_req && run_q && !suspended) begin
      sp_n = 1'b1;
      go_n = 1'b1;
    end else if (resume_go) begin
      sp_n = 1'b0;
    end else if (alg_done && !suspended) begin
      run_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      suspended <= 1'b0;
      susp_sect <= '0;
      susp_go   <= 1'b0;
    end else begin
      run_q     <= run_n;
      suspended <= sp_n;
      susp_sect <= sect_n;
      susp_go   <= go_n;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int SECT_W   = 3,
  parameter int UNLOCK_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              alg_busy,
  input  logic              alg_done,
  output logic              pgm_go,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [7:0]        pgm_data,
  output logic              chip_go,
  output logic              sect_go,
  output logic [SECT_W-1:0] sect_num,
  output logic              susp_go,
  output logic              resume_go,
  output logic [1:0]        mode
);

  logic [1:0] rst_sync;
  logic       core_rst_n;
  logic at_a, at_b, d_key1, d_key2, d_prog, d_erase, d_chip, d_sect, d_susp;
  logic wr_ok, susp_req, suspended;
  logic [SECT_W-1:0] susp_sect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  assign wr_ok    = wr_en && !alg_busy;
  assign susp_req = wr_en && alg_busy && d_susp;

  cmd_match #(.UNLOCK_W(UNLOCK_W)) u_match (
    .key_addr (wr_addr[UNLOCK_W-1:0]),
    .data     (wr_data),
    .at_a     (at_a),
    .at_b     (at_b),
    .d_key1   (d_key1),
    .d_key2   (d_key2),
    .d_prog   (d_prog),
    .d_erase  (d_erase),
    .d_chip   (d_chip),
    .d_sect   (d_sect),
    .d_susp   (d_susp)
  );

  cmd_seq #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_seq (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .wr_ok     (wr_ok),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .at_a      (at_a),
    .at_b      (at_b),
    .d_key1    (d_key1),
    .d_key2    (d_key2),
    .d_prog    (d_prog),
    .d_erase   (d_erase),
    .d_chip    (d_chip),
    .d_sect    (d_sect),
    .suspended (suspended),
    .susp_sect (susp_sect),
    .pgm_go    (pgm_go),
    .pgm_addr  (pgm_addr),
    .pgm_data  (pgm_data),
    .chip_go   (chip_go),
    .sect_go   (sect_go),
    .sect_num  (sect_num),
    .resume_go (resume_go)
  );

  susp_ctrl #(.SECT_W(SECT_W)) u_susp (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .sect_go   (sect_go),
    .sect_id   (sect_num),
    .susp_req  (susp_req),
    .resume_go (resume_go),
    .alg_done  (alg_done),
    .suspended (suspended),
    .susp_sect (susp_sect),
    .susp_go   (susp_go)
  );

  always_comb begin
    if (alg_busy)       mode = MODE_BUSY;
    else if (suspended) mode = MODE_SUSP;
    else                mode = MODE_READ;
  end

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       alg_busy,
  input logic       pgm_go,
  input logic       chip_go,
  input logic       sect_go,
  input logic       susp_go,
  input logic       resume_go,
  input logic [1:0] mode
);

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pgm_go, chip_go, sect_go, susp_go, resume_go})); // R13

  AST_PGM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_go |=> !pgm_go); // R2

  AST_SECT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sect_go |=> !sect_go); // R4

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && alg_busy) |=> !(pgm_go || chip_go || sect_go || resume_go)); // R8

  AST_SUSP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    susp_go |-> ($past(wr_en) && $past(alg_busy) && ($past(wr_data) == 8'hB0))); // R9

  AST_SUSP_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    susp_go |-> (mode != 2'd0)); // R12

  AST_RESUME_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    resume_go |-> ($past(mode) == 2'd2)); // R10

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk u_chk (.*);

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;

  logic        clk = 1'b0;
  logic        rst_n, wr_en, alg_busy, alg_done;
  logic [18:0] wr_addr;
  logic [7:0]  wr_data;
  logic        pgm_go, chip_go, sect_go, susp_go, resume_go;
  logic [18:0] pgm_addr;
  logic [7:0]  pgm_data;
  logic [2:0]  sect_num;
  logic [1:0]  mode;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [4:0] obs;

  always #2.5 clk = ~clk;

  flash_cmd_decoder u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    obs = {pgm_go, chip_go, sect_go, susp_go, resume_go};
  endtask

  task automatic exp5(input string req, input logic [4:0] e);
    chk(obs === e, req, "pulses{pgm,chip,sect,susp,res}", {27'd0, obs}, {27'd0, e});
  endtask

  task automatic unlock3(input logic [7:0] third);
    wr(19'h00555, 8'hAA); exp5("R5", 5'b0);
    wr(19'h002AA, 8'h55); exp5("R5", 5'b0);
    wr(19'h00555, third); exp5("R5", 5'b0);
  endtask

  task automatic prog(input logic [18:0] a, input logic [7:0] d, input logic [4:0] e, input string req);
    unlock3(8'hA0);
    wr(a, d); exp5(req, e);
    if (e[4]) begin
      chk(pgm_addr === a, req, "pgm_addr", {13'd0, pgm_addr}, {13'd0, a});
      chk(pgm_data === d, req, "pgm_data", {24'd0, pgm_data}, {24'd0, d});
    end
  endtask

  task automatic erase(input logic [18:0] a, input logic [7:0] d, input logic [4:0] e, input string req);
    unlock3(8'h80);
    wr(19'h00555, 8'hAA); exp5(req, 5'b0);
    wr(19'h002AA, 8'h55); exp5(req, 5'b0);
    wr(a, d); exp5(req, e);
  endtask

  task automatic chk_mode(input logic [1:0] e, input string req);
    @(negedge clk);
    chk(mode === e, req, "mode", {30'd0, mode}, {30'd0, e});
  endtask

  task automatic pulse_done;
    @(negedge clk); alg_done = 1'b1;
    @(negedge clk); alg_done = 1'b0;
  endtask

  // Bench model of the sequencer with no busy and no suspension.
  task automatic model(inout int st, input logic [18:0] a, input logic [7:0] d,
                       output logic [4:0] e);
    bit ka, kb;
    ka = (a[10:0] == 11'h555);
    kb = (a[10:0] == 11'h2AA);
    e = 5'b0;
    case (st)
      0: st = (d == 8'hAA && ka) ? 1 : 0;
      1: st = (d == 8'h55 && kb) ? 2 : 0;
      2: st = (d == 8'hA0 && ka) ? 3 : ((d == 8'h80 && ka) ? 4 : 0);
      3: begin e = 5'b10000; st = 0; end
      4: st = (d == 8'hAA && ka) ? 5 : 0;
      5: st = (d == 8'h55 && kb) ? 6 : 0;
      default: begin
        if (d == 8'h10 && ka) e = 5'b01000;
        else if (d == 8'h30) e = 5'b00100;
        st = 0;
      end
    endcase
  endtask

  initial begin
    #(5ns * 200000);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int st;
    logic [4:0] e;
    logic [7:0] dsel [7];
    void'($urandom(32'd4242));
    dsel = '{8'hAA, 8'h55, 8'hA0, 8'h80, 8'h10, 8'h30, 8'hF0};
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    alg_busy = 1'b0; alg_done = 1'b0;
    repeat (3) @(negedge clk);
    obs = {pgm_go, chip_go, sect_go, susp_go, resume_go};
    exp5("R1", 5'b0);
    chk(mode === 2'd0, "R1", "mode", {30'd0, mode}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    prog(19'h12345, 8'h5A, 5'b10000, "R2");
    erase(19'h00555, 8'h10, 5'b01000, "R3");
    erase(19'h5ABCD, 8'h30, 5'b00100, "R4");
    chk(sect_num === 3'd5, "R4", "sect_num", {29'd0, sect_num}, 32'd5);

    // R7: upper bits vary on unlock writes
    wr(19'h7F555, 8'hAA); wr(19'h3A2AA, 8'h55); wr(19'h00D55, 8'hA0);
    wr(19'h0BEEF, 8'hC3); exp5("R7", 5'b10000);
    chk(pgm_data === 8'hC3, "R7", "pgm_data", {24'd0, pgm_data}, 32'hC3);

    // R5: bad address then bad data
    wr(19'h00555, 8'hAA); wr(19'h002AB, 8'h55); wr(19'h00555, 8'hA0);
    wr(19'h00100, 8'h11); exp5("R5", 5'b0);
    unlock3(8'h12); wr(19'h00100, 8'h11); exp5("R5", 5'b0);
    prog(19'h00200, 8'h22, 5'b10000, "R5");

    // R6: reset code mid-erase
    unlock3(8'h80); wr(19'h00123, 8'hF0); exp5("R6", 5'b0);
    wr(19'h00555, 8'h10); exp5("R6", 5'b0);

    // R8: ignored while busy
    alg_busy = 1'b1; chk_mode(2'd1, "R12");
    prog(19'h00300, 8'h33, 5'b0, "R8");
    erase(19'h00555, 8'h10, 5'b0, "R8");
    alg_busy = 1'b0; chk_mode(2'd0, "R12");
    wr(19'h00555, 8'hAA); wr(19'h002AA, 8'h55); alg_busy = 1'b1;
    wr(19'h00000, 8'hF0); exp5("R8", 5'b0);
    alg_busy = 1'b0;
    wr(19'h00555, 8'hA0); wr(19'h00400, 8'h44); exp5("R8", 5'b10000);

    // R9: B0 without erase or without busy does nothing
    wr(19'h00000, 8'hB0); exp5("R9", 5'b0);
    erase(19'h20000, 8'h30, 5'b00100, "R4");
    alg_busy = 1'b1; chk_mode(2'd1, "R12");
    wr(19'h01234, 8'hB0); exp5("R9", 5'b00010);
    alg_busy = 1'b0; chk_mode(2'd2, "R9");

    // R11: suspended sector protected
    prog(19'h21234, 8'h55, 5'b0, "R11");
    prog(19'h41234, 8'h66, 5'b10000, "R11");
    alg_busy = 1'b1; chk_mode(2'd1, "R12");
    pulse_done; alg_busy = 1'b0; chk_mode(2'd2, "R11");
    erase(19'h60000, 8'h30, 5'b0, "R11");
    chk_mode(2'd2, "R11");

    // R10: resume
    wr(19'h06000, 8'h30); exp5("R10", 5'b00001);
    chk_mode(2'd0, "R10");
    alg_busy = 1'b1; pulse_done;
    wr(19'h00000, 8'hB0); exp5("R9", 5'b0);
    alg_busy = 1'b0;
    wr(19'h06000, 8'h30); exp5("R10", 5'b0);

    // random phase against the bench model (R2-R7, R13)
    st = 0;
    for (int i = 0; i < 1500; i++) begin
      logic [18:0] a;
      logic [7:0]  d;
      int k, j;
      k = $urandom % 8;
      j = $urandom % 4;
      d = (k < 7) ? dsel[k] : 8'($urandom);
      case (j)
        0, 3: a = {8'($urandom), 11'h555};
        1:    a = {8'($urandom), 11'h2AA};
        default: a = 19'($urandom);
      endcase
      model(st, a, d, e);
      wr(a, d);
      exp5("R13", e);
      if (e[4]) chk(pgm_addr === a && pgm_data === d, "R2", "pgm addr/data",
                    {5'd0, pgm_addr, pgm_data}, {5'd0, a, d});
      if (e[2]) chk(sect_num === a[18:16], "R4", "sect_num",
                    {29'd0, sect_num}, {29'd0, a[18:16]});
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule